// File: doc/BRIEF.md
# Segmented Paged Address Translator

This block turns a 15-bit virtual address into a 15-bit physical address for a small memory that is split into four segments of four pages each. The top two bits of the virtual address pick the segment, the next two pick the page within it, and the low eleven bits are the byte offset inside a 2 KB page. Each segment carries a protection class that says whether stores and instruction fetches are allowed. Each page carries a resident flag and a 4-bit frame number that selects one of sixteen 2 KB frames in a 32 KB physical space.

A request is offered on a valid/ready channel together with its access kind. The result appears on an output valid/ready channel in the cycle after the request is taken. Back-pressure works as follows. The request side is ready whenever the output register is empty or is being drained in the same cycle. While a result waits with `out_ready` low, that result stays frozen and no new request is accepted. With `out_ready` held high, `out_valid` is a one-cycle done pulse for each request.

Table contents are written through a plain single-cycle write port. A write that lands in the same cycle as an accepted request does not affect that request.

Top module: `seg_page_xlate`

## Requirements
- R1: When the access is permitted and the page is resident, `out_paddr` equals the page's 4-bit frame number placed above the 11-bit offset `req_vaddr[10:0]`. The segment is `req_vaddr[14:13]` and the page is `req_vaddr[12:11]`. `out_fault` is 00 in this case.
- R2: An access to a page whose resident flag is 0 reports `out_fault` = 01 (page fault), provided no protection fault applies. Any result with a nonzero fault code carries `out_paddr` = 0.
- R3: A store (`req_acc` = 01) to a segment whose class has bit 1 clear reports `out_fault` = 10. The classes are 00 read-only, 01 read/execute, 10 read/write and 11 read/write/execute.
- R4: An instruction fetch (`req_acc` = 10) to a segment whose class has bit 0 clear reports `out_fault` = 10.
- R5: A data read (`req_acc` = 00) is never a protection fault, whatever the class.
- R6: When an access breaks protection and also targets a non-resident page, the protection fault (10) is reported.
- R7: A request taken at a clock edge (`req_valid` and `req_ready` both high) produces `out_valid` high right after that edge.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_paddr` and `out_fault` hold their values and `req_ready` is low.
- R9: After reset `out_valid` is 0, every page is non-resident and every segment is read-only.
- R10: A table write with `tbl_sel` = 0 sets the page entry (`tbl_seg`, `tbl_page`) to resident flag `tbl_data[4]` and frame `tbl_data[3:0]`. A table write with `tbl_sel` = 1 sets the class of segment `tbl_seg` to `tbl_data[1:0]`.
- R11: The access code 11 is handled as a data read. The fault code 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_vaddr | input | 15 | Virtual address: segment, page, offset |
| req_acc | input | 2 | Access kind: 00 read, 01 store, 10 fetch, 11 read |
| out_valid | output | 1 | Result present (done) |
| out_ready | input | 1 | Consumer takes the result |
| out_paddr | output | 15 | Physical address, zero on fault |
| out_fault | output | 2 | 00 none, 01 page fault, 10 protection fault |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 1 | 0 page entry, 1 segment class |
| tbl_seg | input | 2 | Segment addressed by the write |
| tbl_page | input | 2 | Page addressed by a page-entry write |
| tbl_data | input | 5 | {resident, frame} or class in bits 1:0 |

## Verification
On every cycle, the assertions check four things: that a faulting result carries a zero address, that the fault code 11 never shows, that a stalled result stays frozen, and that an accepted request yields a result on the next cycle. The correct address for each mix of class, residency, frame and access kind, including the precedence of protection over page faults, can only be shown by the bench. It does this by sweeping every segment, page and access code under two different table images. Reset contents, and the way a blocked request waits and is then taken, are likewise shown only by directed scenarios.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_ALT   = 2'b11
  } acc_t;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_PAGE = 2'b01,
    FLT_PROT = 2'b10
  } fault_t;
endpackage

// File: rtl/seg_class_table.sv
module seg_class_table #(
  parameter int SEG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_seg,
  input  logic [1:0]       wr_cls,
  input  logic [SEG_W-1:0] rd_seg,
  output logic [1:0]       rd_cls
);
  localparam int NSEG = 1 << SEG_W;

  logic [1:0] cls_q [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rst_n)
        cls_q[g] <= 2'b00;
      else if (wr_en && wr_seg == SEG_W'(g))
        cls_q[g] <= wr_cls;
    end
  end

  assign rd_cls = cls_q[rd_seg];
endmodule

// File: rtl/page_entry_table.sv
module page_entry_table #(
  parameter int SEG_W   = 2,
  parameter int PAGE_W  = 2,
  parameter int FRAME_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SEG_W+PAGE_W-1:0] wr_idx,
  input  logic                    wr_res,
  input  logic [FRAME_W-1:0]      wr_frame,
  input  logic [SEG_W+PAGE_W-1:0] rd_idx,
  output logic                    rd_res,
  output logic [FRAME_W-1:0]      rd_frame
);
  localparam int IDX_W = SEG_W + PAGE_W;
  localparam int NENT  = 1 << IDX_W;

  logic               res_q   [NENT];
  logic [FRAME_W-1:0] frame_q [NENT];

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res_q[g]   <= 1'b0;
        frame_q[g] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        res_q[g]   <= wr_res;
        frame_q[g] <= wr_frame;
      end
    end
  end

  assign rd_res   = res_q[rd_idx];
  assign rd_frame = frame_q[rd_idx];
endmodule

// File: rtl/access_check.sv
module access_check
  import xlate_pkg::*;
(
  input  logic [1:0] cls,
  input  acc_t       acc,
  input  logic       resident,
  output fault_t     fault
);
  logic prot_bad;

  always_comb begin
    prot_bad = ((acc == ACC_WRITE) && !cls[1]) ||
               ((acc == ACC_FETCH) && !cls[0]);
    if (prot_bad)
      fault = FLT_PROT;
    else if (!resident)
      fault = FLT_PAGE;
    else
      fault = FLT_NONE;
  end
endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
  import xlate_pkg::*;
#(
  parameter int SEG_W   = 2,
  parameter int PAGE_W  = 2,
  parameter int OFF_W   = 11,
  parameter int FRAME_W = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0]     req_vaddr,
  input  logic [1:0]                        req_acc,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic [FRAME_W+OFF_W-1:0]          out_paddr,
  output logic [1:0]                        out_fault,
  input  logic                              tbl_we,
  input  logic                              tbl_sel,
  input  logic [SEG_W-1:0]                  tbl_seg,
  input  logic [PAGE_W-1:0]                 tbl_page,
  input  logic [FRAME_W:0]                  tbl_data
);
  localparam int VA_W  = SEG_W + PAGE_W + OFF_W;
  localparam int PA_W  = FRAME_W + OFF_W;
  localparam int IDX_W = SEG_W + PAGE_W;

  logic [SEG_W-1:0]   va_seg;
  logic [IDX_W-1:0]   va_idx;
  logic [OFF_W-1:0]   va_off;
  logic [1:0]         seg_cls;
  logic               pg_res;
  logic [FRAME_W-1:0] pg_frame;
  fault_t             chk_fault;
  logic               take;

  assign va_seg = req_vaddr[VA_W-1 -: SEG_W];
  assign va_idx = req_vaddr[VA_W-1 -: IDX_W];
  assign va_off = req_vaddr[OFF_W-1:0];

  seg_class_table #(.SEG_W(SEG_W)) u_cls (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (tbl_we && tbl_sel),
    .wr_seg (tbl_seg),
    .wr_cls (tbl_data[1:0]),
    .rd_seg (va_seg),
    .rd_cls (seg_cls)
  );

  page_entry_table #(.SEG_W(SEG_W), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_pte (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_we && !tbl_sel),
    .wr_idx   ({tbl_seg, tbl_page}),
    .wr_res   (tbl_data[FRAME_W]),
    .wr_frame (tbl_data[FRAME_W-1:0]),
    .rd_idx   (va_idx),
    .rd_res   (pg_res),
    .rd_frame (pg_frame)
  );

  access_check u_chk (
    .cls      (seg_cls),
    .acc      (acc_t'(req_acc)),
    .resident (pg_res),
    .fault    (chk_fault)
  );

  assign req_ready = !out_valid || out_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_paddr <= '0;
      out_fault <= FLT_NONE;
    end else if (take) begin
      out_valid <= 1'b1;
      out_fault <= chk_fault;
      out_paddr <= (chk_fault == FLT_NONE) ? PA_W'({pg_frame, va_off}) : '0;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_fault_zero_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fault != FLT_NONE) |-> (out_paddr == '0));

  assert_no_code3_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_fault != 2'b11));

  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_paddr) && $stable(out_fault)));

  assert_done_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> out_valid);
endmodule

// File: tb/test_seg_page_xlate.sv
module test_seg_page_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [14:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [14:0] out_paddr;
  logic [1:0]  out_fault;
  logic        tbl_we = 1'b0;
  logic        tbl_sel = 1'b0;
  logic [1:0]  tbl_seg = '0;
  logic [1:0]  tbl_page = '0;
  logic [4:0]  tbl_data = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_page_xlate i_seg_page_xlate (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_acc(req_acc),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_paddr(out_paddr), .out_fault(out_fault),
    .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_seg(tbl_seg),
    .tbl_page(tbl_page), .tbl_data(tbl_data)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int cls_of(int s, int ph);
    return ph ? (s + 1) % 4 : s;
  endfunction
  function automatic int res_of(int s, int p, int ph);
    return (((s * 4 + p) % 3) != 0) ^ ph;
  endfunction
  function automatic int frame_of(int s, int p, int ph);
    return (s * 5 + p * 3 + 1 + ph * 7) % 16;
  endfunction

  function automatic int exp_fault(int cls, int res, int acc);
    if (acc == 1 && (cls & 2) == 0) return 2;
    if (acc == 2 && (cls & 1) == 0) return 2;
    if (res == 0) return 1;
    return 0;
  endfunction

  task automatic tbl_write(input logic sel, input int s, input int p, input int d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = sel; tbl_seg = 2'(s); tbl_page = 2'(p); tbl_data = 5'(d);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic load_image(input int ph);
    for (int s = 0; s < 4; s++) begin
      tbl_write(1'b1, s, 0, cls_of(s, ph));
      for (int p = 0; p < 4; p++)
        tbl_write(1'b0, s, p, res_of(s, p, ph) * 16 + frame_of(s, p, ph));
    end
  endtask

  task automatic xlate(input int va, input int acc, input string req,
                       input int e_pa, input int e_flt);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 15'(va); req_acc = 2'(acc);
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R7 valid"}, int'(out_valid), 1);
    check({req, " fault"}, int'(out_fault), e_flt);
    check({req, " paddr"}, int'(out_paddr), e_pa);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 out_valid after reset", int'(out_valid), 0);
    check("R9 req_ready after reset", int'(req_ready), 1);
    // R9: reset table is non-resident and read-only
    xlate(15'h2345, 0, "R9 read after reset", 0, 1);
    xlate(15'h0123, 1, "R9 store after reset", 0, 2);

    for (int ph = 0; ph < 2; ph++) begin
      load_image(ph);
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 4; p++)
          for (int a = 0; a < 4; a++)
            for (int k = 0; k < 3; k++) begin
              int off, cls, res, fr, ef, ep, va;
              string tag;
              off = (k == 0) ? 0 : (k == 1) ? 2047 : (s * 300 + p * 77 + a * 13) % 2048;
              cls = cls_of(s, ph);
              res = res_of(s, p, ph);
              fr  = frame_of(s, p, ph);
              ef  = exp_fault(cls, res, a);
              ep  = (ef == 0) ? fr * 2048 + off : 0;
              va  = s * 8192 + p * 2048 + off;
              if (ef == 2 && res == 0) tag = "R6 prot over page";
              else if (ef == 2 && a == 1) tag = "R3 store prot";
              else if (ef == 2) tag = "R4 fetch prot";
              else if (ef == 1) tag = "R2 page fault";
              else if (a == 3) tag = "R11 alt code as read";
              else if (a == 0) tag = "R5 read R1 R10 ok";
              else tag = "R1 R10 translate";
              xlate(va, a, tag, ep, ef);
            end
    end

    // R8: back-pressure, image from phase 1 is loaded
    @(negedge clk);
    out_ready = 1'b0;
    req_valid = 1'b1; req_vaddr = 15'(0 * 8192 + 2 * 2048 + 5); req_acc = 2'd0;
    @(negedge clk);
    check("R8 first result valid", int'(out_valid), 1);
    check("R8 ready low while stalled", int'(req_ready), 0);
    req_vaddr = 15'(1 * 8192 + 1 * 2048 + 9);
    @(negedge clk);
    @(negedge clk);
    check("R8 held valid", int'(out_valid), 1);
    check("R8 held paddr", int'(out_paddr),
          res_of(0, 2, 1) ? frame_of(0, 2, 1) * 2048 + 5 : 0);
    check("R8 held fault", int'(out_fault), res_of(0, 2, 1) ? 0 : 1);
    out_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 second valid", int'(out_valid), 1);
    check("R8 second paddr", int'(out_paddr),
          res_of(1, 1, 1) ? frame_of(1, 1, 1) * 2048 + 9 : 0);
    @(negedge clk);
    check("R7 done pulse ends", int'(out_valid), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule